// File: doc/BRIEF.md
# Two-Line Serial Packet Receiver

This block recovers a command packet that software sends by toggling two select lines of a keypad port. Each processor write to the port hands the block a 2-bit line value. The value encodes everything: a reset pulse, a one bit, a clock tick that moves the bit pointer, and an end marker. The block fills a 16-byte buffer least significant bit first. When the end marker arrives with the pointer just past the last bit, it raises a one-cycle valid strobe. The buffer then holds the finished packet until the next reset pulse.

The same stream of line values also steps a controller index for multiplayer selection. A fall from a high upper line to a low one toggles an internal increment flag. The next rise to both-lines-high, while the flag is set, moves the index on by one, wrapped by a controller-count mask. What the packet contents mean is left to the logic downstream.

Top module: `sel_line_pkt_rx`

## Requirements
- R1: While reset is held and right after it, `ctrl_idx` is 0, `pkt_valid` is 0 and `pkt_data` is all zeros. The pointer is idle, the increment flag is clear and the recorded line value is 2'b11.
- R2: A write of 2'b00 makes the pointer idle and clears all of `pkt_data`. This happens even when the recorded value is already 2'b00.
- R3: Other than the clearing in R2, a write whose value equals the recorded value has no effect on any output or on the pointer.
- R4: A write of 2'b01 sets bit `ptr` of `pkt_data`, which is bit `ptr&7` of byte `ptr>>3`, with byte k at `pkt_data[8k+7:8k]`. While the pointer is idle it sets nothing.
- R5: A write of 2'b11 moves the pointer from idle to 0, or from n to n+1 while n is below 128.
- R6: A write of 2'b10 while the pointer is 128 makes `pkt_valid` high for exactly the one cycle after the write and moves the pointer to 129. No further strobe comes until a 2'b00 write.
- R7: While the pointer is 128 or above, writes store no bits and do not move the pointer.
- R8: A changed write of 2'b00 or 2'b01, where the recorded value has bit 1 set, toggles the increment flag.
- R9: A changed write of 2'b11 while the flag is set clears the flag and loads `ctrl_idx` with `(ctrl_idx + 1) & ctrl_mask`. The mask used is the one present on that write.
- R10: After a strobe, `pkt_data` keeps the packet unchanged until a 2'b00 write.
- R11: Cycles with `wr_en` low change no state, whatever is on `line_val` and `ctrl_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One cycle per processor write to the keypad port |
| line_val | input | 2 | Select-line value carried by the write |
| ctrl_mask | input | CTRL_W (2) | Controller-count wrap mask |
| pkt_data | output | PKT_BYTES*8 (128) | Assembled packet, byte 0 in the low bits |
| pkt_valid | output | 1 | One-cycle packet-complete strobe |
| ctrl_idx | output | CTRL_W (2) | Current controller index |

## Verification
The bench sends whole packets with several data patterns and checks where the first bit lands. A pointer that starts at 1 instead of 0, or that fills bits MSB first, would show up there as shifted or mirrored bytes. It also repeats a value to prove the repeat is ignored: a design that ticks on a level instead of a change would drop every packet bit one place too far. It drives the pointer past the end and sends 01 and 10 again, which a design without saturation would show as stray bits or a second strobe. A long pseudo-random sweep over every mask value compares the controller index after each write. That catches a flag that toggles on the wrong transition, or an index that ignores the mask.

// File: rtl/slpr_pkg.sv
package slpr_pkg;
  // Line encodings carried by each port write
  typedef enum logic [1:0] {
    LN_CLEAR = 2'b00,
    LN_ONE   = 2'b01,
    LN_END   = 2'b10,
    LN_TICK  = 2'b11
  } line_e;

  localparam logic [1:0] LINE_AFTER_RESET = 2'b11;
endpackage

// File: rtl/slpr_line_dec.sv
module slpr_line_dec
  import slpr_pkg::*;
#(
  parameter int PKT_BITS = 128,
  parameter int PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       line_val,
  input  logic             ptr_idle,
  input  logic [PTR_W-1:0] ptr_cnt,
  output logic [1:0]       prev_line,
  output logic             ev_clear,
  output logic             ev_toggle,
  output logic             ev_step,
  output logic             ev_set,
  output logic             ev_adv,
  output logic             ev_deliver
);
  localparam logic [PTR_W-1:0] END_PTR = PTR_W'(PKT_BITS);

  logic [1:0] prev_q;
  logic       changed;
  logic       below_end;
  logic       at_end;

  assign prev_line = prev_q;
  assign changed   = wr_en && (line_val != prev_q);
  assign below_end = ptr_idle || (ptr_cnt < END_PTR);
  assign at_end    = !ptr_idle && (ptr_cnt == END_PTR);

  // clear fires on any 00 write, changed or not
  assign ev_clear   = wr_en && (line_val == LN_CLEAR);
  assign ev_toggle  = changed && !line_val[1] && prev_q[1];
  assign ev_step    = changed && (line_val == LN_TICK);
  assign ev_set     = changed && (line_val == LN_ONE) && !ptr_idle && below_end;
  assign ev_adv     = changed && (line_val == LN_TICK) && below_end;
  assign ev_deliver = changed && (line_val == LN_END) && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= LINE_AFTER_RESET;
    else if (changed) prev_q <= line_val;
  end
endmodule

// File: rtl/slpr_bit_ptr.sv
module slpr_bit_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_clear,
  input  logic             ev_adv,
  input  logic             ev_deliver,
  output logic             ptr_idle,
  output logic [PTR_W-1:0] ptr_cnt
);
  logic             idle_q;
  logic [PTR_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic idle, input logic [PTR_W-1:0] c);
    return idle ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ev_clear) begin
      idle_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ev_adv || ev_deliver) begin
      idle_q <= 1'b0;
      cnt_q  <= bump(idle_q, cnt_q);
    end
  end

  assign ptr_idle = idle_q;
  assign ptr_cnt  = cnt_q;
endmodule

// File: rtl/slpr_pkt_buf.sv
module slpr_pkt_buf #(
  parameter int PKT_BYTES = 16,
  parameter int IDX_W     = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_clear,
  input  logic                   ev_set,
  input  logic [IDX_W-1:0]       bit_idx,
  output logic [PKT_BYTES*8-1:0] pkt_data
);
  localparam int BYTE_W = IDX_W - 3;

  function automatic logic [7:0] lane_mask(input logic [2:0] sel);
    return 8'b1 << sel;
  endfunction

  for (genvar b = 0; b < PKT_BYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;
    assign hit = ev_set && (bit_idx[IDX_W-1:3] == BYTE_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byte_q <= '0;
      else if (ev_clear) byte_q <= '0;
      else if (hit)      byte_q <= byte_q | lane_mask(bit_idx[2:0]);
    end
    assign pkt_data[8*b +: 8] = byte_q;
  end
endmodule

// File: rtl/slpr_ctrl_step.sv
module slpr_ctrl_step #(
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_toggle,
  input  logic              ev_step,
  input  logic [CTRL_W-1:0] ctrl_mask,
  output logic [CTRL_W-1:0] ctrl_idx
);
  logic              flag_q;
  logic [CTRL_W-1:0] idx_q;

  function automatic logic [CTRL_W-1:0] next_idx(input logic [CTRL_W-1:0] cur,
                                                 input logic [CTRL_W-1:0] m);
    return (cur + 1'b1) & m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      idx_q  <= '0;
    end else if (ev_toggle) begin
      flag_q <= !flag_q;
    end else if (ev_step && flag_q) begin
      flag_q <= 1'b0;
      idx_q  <= next_idx(idx_q, ctrl_mask);
    end
  end

  assign ctrl_idx = idx_q;
endmodule

// File: rtl/sel_line_pkt_rx.sv
module sel_line_pkt_rx #(
  parameter int PKT_BYTES = 16,
  parameter int CTRL_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             line_val,
  input  logic [CTRL_W-1:0]      ctrl_mask,
  output logic [PKT_BYTES*8-1:0] pkt_data,
  output logic                   pkt_valid,
  output logic [CTRL_W-1:0]      ctrl_idx
);
  localparam int PKT_BITS = PKT_BYTES * 8;
  localparam int IDX_W    = $clog2(PKT_BITS);
  localparam int PTR_W    = IDX_W + 1;

  logic [1:0]       prev_line;
  logic             ptr_idle;
  logic [PTR_W-1:0] ptr_cnt;
  logic             ev_clear, ev_toggle, ev_step, ev_set, ev_adv, ev_deliver;
  logic             valid_q;

  slpr_line_dec #(.PKT_BITS(PKT_BITS), .PTR_W(PTR_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .line_val(line_val),
    .ptr_idle(ptr_idle), .ptr_cnt(ptr_cnt), .prev_line(prev_line),
    .ev_clear(ev_clear), .ev_toggle(ev_toggle), .ev_step(ev_step),
    .ev_set(ev_set), .ev_adv(ev_adv), .ev_deliver(ev_deliver)
  );

  slpr_bit_ptr #(.PTR_W(PTR_W)) ptr_i (
    .clk(clk), .rst_n(rst_n), .ev_clear(ev_clear), .ev_adv(ev_adv),
    .ev_deliver(ev_deliver), .ptr_idle(ptr_idle), .ptr_cnt(ptr_cnt)
  );

  slpr_pkt_buf #(.PKT_BYTES(PKT_BYTES), .IDX_W(IDX_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .ev_clear(ev_clear), .ev_set(ev_set),
    .bit_idx(ptr_cnt[IDX_W-1:0]), .pkt_data(pkt_data)
  );

  slpr_ctrl_step #(.CTRL_W(CTRL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ev_toggle(ev_toggle), .ev_step(ev_step),
    .ctrl_mask(ctrl_mask), .ctrl_idx(ctrl_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= ev_deliver;
  end

  assign pkt_valid = valid_q;
endmodule

// File: rtl/sel_line_pkt_rx_chk.sv
module sel_line_pkt_rx_chk #(
  parameter int PKT_BYTES = 16,
  parameter int CTRL_W    = 2,
  parameter int PTR_W     = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [1:0]             line_val,
  input logic [CTRL_W-1:0]      ctrl_mask,
  input logic [PKT_BYTES*8-1:0] pkt_data,
  input logic                   pkt_valid,
  input logic [CTRL_W-1:0]      ctrl_idx,
  input logic [1:0]             prev_line,
  input logic                   ptr_idle,
  input logic [PTR_W-1:0]       ptr_cnt
);
  localparam logic [PTR_W-1:0] END_PTR = PTR_W'(PKT_BYTES * 8);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (ctrl_idx == '0 && !pkt_valid && pkt_data == '0));

  assert_clear_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && line_val == 2'b00) |=> (pkt_data == '0 && ptr_idle));

  assert_repeat_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && line_val == prev_line && line_val != 2'b00)
      |=> ($stable(pkt_data) && $stable(ctrl_idx) && $stable(ptr_cnt) && !pkt_valid));

  assert_one_bit_per_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pkt_data) <= $countones($past(pkt_data)) + 1);

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);

  assert_strobe_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(wr_en && line_val == 2'b10));

  assert_no_store_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_idle && ptr_cnt >= END_PTR && line_val != 2'b00)
      |=> ($stable(pkt_data) && ptr_cnt >= END_PTR));

  assert_idx_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_idx) |->
      (ctrl_idx == (($past(ctrl_idx) + 1'b1) & $past(ctrl_mask))));

  assert_idle_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pkt_data) && $stable(ctrl_idx) && !pkt_valid));
endmodule

bind sel_line_pkt_rx sel_line_pkt_rx_chk #(
  .PKT_BYTES(PKT_BYTES), .CTRL_W(CTRL_W), .PTR_W(PTR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .line_val(line_val),
  .ctrl_mask(ctrl_mask), .pkt_data(pkt_data), .pkt_valid(pkt_valid),
  .ctrl_idx(ctrl_idx), .prev_line(prev_line), .ptr_idle(ptr_idle),
  .ptr_cnt(ptr_cnt)
);

// File: tb/sel_line_pkt_rx_tb_top.sv
module sel_line_pkt_rx_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   line_val = 2'b00;
  logic [1:0]   ctrl_mask = 2'b00;
  logic [127:0] pkt_data;
  logic         pkt_valid;
  logic [1:0]   ctrl_idx;

  int n_chk = 0;
  int n_bad = 0;

  // independent reference state
  int           m_ptr;
  logic [1:0]   m_prev;
  logic         m_flag;
  logic [1:0]   m_idx;
  logic [127:0] m_pkt;
  logic         m_valid;

  always #5 clk = ~clk;

  sel_line_pkt_rx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .line_val(line_val),
    .ctrl_mask(ctrl_mask), .pkt_data(pkt_data), .pkt_valid(pkt_valid),
    .ctrl_idx(ctrl_idx)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(pkt_data == m_pkt, req, pkt_data, m_pkt);
    check(pkt_valid == m_valid, req, 128'(pkt_valid), 128'(m_valid));
    check(ctrl_idx == m_idx, req, 128'(ctrl_idx), 128'(m_idx));
  endtask

  task automatic model_write(input logic [1:0] v, input logic [1:0] msk);
    m_valid = 1'b0;
    if (v == 2'b00) begin
      m_ptr = -1;
      m_pkt = '0;
    end
    if (v != m_prev) begin
      if (!v[1] && m_prev[1]) m_flag = !m_flag;
      else if (v == 2'b11 && m_flag) begin
        m_flag = 1'b0;
        m_idx = (m_idx + 2'd1) & msk;
      end
      m_prev = v;
      if (m_ptr == 128 && v == 2'b10) begin
        m_valid = 1'b1;
        m_ptr = 129;
      end else if (v == 2'b01 && m_ptr >= 0 && m_ptr < 128) begin
        m_pkt[m_ptr] = 1'b1;
      end else if (v == 2'b11 && m_ptr < 128) begin
        m_ptr = m_ptr + 1;
      end
    end
  endtask

  task automatic wr(input logic [1:0] v, input string req);
    @(negedge clk);
    wr_en = 1'b1;
    line_val = v;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(v, ctrl_mask);
    check_all(req);
  endtask

  task automatic send_packet(input logic [127:0] d);
    wr(2'b00, "R2");
    for (int i = 0; i < 128; i++) begin
      wr(2'b11, "R5");
      wr(d[i] ? 2'b01 : 2'b10, "R4");
    end
    wr(2'b11, "R5");
    wr(2'b10, "R6");
    check(pkt_valid == 1'b1, "R6", 128'(pkt_valid), 128'd1);
    check(pkt_data == d, "R4", pkt_data, d);
    @(negedge clk);
    m_valid = 1'b0;
    check(pkt_valid == 1'b0, "R6", 128'(pkt_valid), 128'd0);
    check(pkt_data == d, "R10", pkt_data, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=expired exp=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0]  lfsr;
    logic [127:0] pat;
    m_ptr = -1; m_prev = 2'b11; m_flag = 1'b0; m_idx = '0; m_pkt = '0; m_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R4: 01 while idle stores nothing; R5: first tick lands on bit 0
    wr(2'b01, "R4");
    wr(2'b00, "R2");
    wr(2'b01, "R4");
    check(pkt_data == '0, "R4", pkt_data, '0);
    wr(2'b11, "R5");
    wr(2'b01, "R5");
    check(pkt_data == 128'd1, "R5", pkt_data, 128'd1);
    // R3: repeated tick ignored, next bit still lands on bit 1
    wr(2'b11, "R3");
    wr(2'b11, "R3");
    wr(2'b01, "R3");
    check(pkt_data == 128'd3, "R3", pkt_data, 128'd3);
    wr(2'b01, "R3");
    // R2: repeated 00 keeps the buffer clear
    wr(2'b00, "R2");
    wr(2'b00, "R2");
    check(pkt_data == '0, "R2", pkt_data, '0);

    // full packets with several patterns
    ctrl_mask = 2'b00;
    send_packet({4{32'hA5C3_0F81}});
    send_packet(128'h1);
    send_packet({128{1'b1}});
    pat = '0;
    for (int k = 0; k < 16; k++) pat[8*k +: 8] = 8'(k * 37 + 5);
    send_packet(pat);

    // R7: beyond the end nothing is stored and no second strobe
    wr(2'b11, "R7");
    wr(2'b01, "R7");
    wr(2'b11, "R7");
    wr(2'b10, "R7");
    check(pkt_valid == 1'b0, "R6", 128'(pkt_valid), 128'd0);
    check(pkt_data == pat, "R10", pkt_data, pat);

    // R11: idle cycles with changing lines
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      line_val = 2'(k);
      ctrl_mask = 2'(k + 1);
      @(negedge clk);
      check_all("R11");
    end
    wr(2'b00, "R2");
    check(pkt_data == '0, "R10", pkt_data, '0);

    // R8/R9 sweep over every mask value
    lfsr = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      if (n % 64 == 0) ctrl_mask = 2'(n / 64);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr(lfsr[1:0], (n % 2 == 0) ? "R8" : "R9");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule